// File: doc/BRIEF.md
# Interrupt Request Collector with Wake and Deferred Delivery

This block gathers a bank of level-sensitive interrupt request lines on behalf of a processor core. Each request line whose enable bit is set in a mask register is latched into a sticky status register. The two lowest lines bypass the mask and always latch. The core reads and writes the mask, the status and a plain priority storage register through a small register port with a select code, a write strobe and a combinational read bus. Software acknowledges an interrupt by writing zeros into the status register.

Any asserted request line wakes the core. This holds whether or not the line is masked: the doze and sleep enable flags of the power-management logic are forced off. The core raises those flags through two set inputs.

The exception request to the core is gated by the core's interrupt-enable flag. While that flag is low, a nonzero status stays pending and is looked at again on every clock. The exception pulse goes out in the first cycle in which the flag reads high. It is a single-cycle pulse, issued once per pending episode.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the mask, priority and status registers read all zeros, the doze and sleep flags are 0 and no exception is requested.
- R2: The register select code is 0 for mask, 1 for priority, 2 for status and 3 for none. Code 3 reads as zero and ignores writes. A request on line N of 2 or more sets status bit N at the next rising edge only when mask bit N is 1.
- R3: A request on line 0 or line 1 sets its status bit at the next rising edge whatever the mask holds.
- R4: A request on a masked line of 2 or more leaves the status register unchanged and causes no exception.
- R5: In any cycle with at least one request line high, masked or not, both the doze and sleep flags read 0 from the next cycle. With no request high, a set input raises its flag at the next edge, and the flag otherwise holds.
- R6: The exception output is high in a cycle only when the status register is nonzero and the interrupt-enable input is high in that same cycle.
- R7: While interrupt enable is low, a nonzero status is held pending with no exception. The exception is raised in the first cycle in which interrupt enable reads high.
- R8: The exception is a one-cycle pulse, issued once per episode. It re-arms only after a cycle in which the status is all zero or interrupt enable is low.
- R9: A status write takes effect at the next edge, and a request latching on the same edge wins over a written 0 for its bit.
- R10: The priority register is plain read/write storage. Its contents change neither latching nor delivery.
- R11: Mask and priority writes take effect at the next edge, and the read bus reflects the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 32 | Level-sensitive interrupt request lines |
| ie_i | input | 1 | Core interrupt-enable flag |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 priority, 2 status, 3 none |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data of the selected register |
| doze_set_i | input | 1 | Core request to enable doze mode |
| sleep_set_i | input | 1 | Core request to enable sleep mode |
| doze_en_o | output | 1 | Doze mode enable flag |
| sleep_en_o | output | 1 | Sleep mode enable flag |
| exc_o | output | 1 | Single-cycle external-interrupt exception request |

## Verification
The latching path gets requests on an enabled line, on a disabled line and on the two unmaskable lines under an all-zero mask. These patterns separate correct gating from a mask that is ignored or applied everywhere. Delivery gets long stretches with interrupt enable low, followed by a rise with status held nonzero, and then a clear-and-refire. These sequences separate deferred delivery, one pulse per episode and re-arming. Same-edge status writes with requests, priority patterns, and a pseudo-random mixed phase compared against a behavioural model on every clock expose ordering and priority-leak faults.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_PRIO = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_LINES  = 32,
  parameter int UNMASKED   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [1:0]           sel_i,
  input  logic                 we_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic [NUM_LINES-1:0] status_o,
  output logic [NUM_LINES-1:0] mask_o
);
  import irq_pkg::*;

  logic [NUM_LINES-1:0] mask_q, prio_q, status_q;
  logic [NUM_LINES-1:0] admit;
  logic [NUM_LINES-1:0] status_base;

  // per-line admission: low lines bypass the mask
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_admit
    if (g < UNMASKED) begin : g_free
      assign admit[g] = req_i[g];
    end else begin : g_gated
      assign admit[g] = req_i[g] & mask_q[g];
    end
  end

  assign status_base = (we_i && sel_i == SEL_STAT) ? wdata_i : status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      prio_q   <= '0;
      status_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_MASK) mask_q <= wdata_i;
      if (we_i && sel_i == SEL_PRIO) prio_q <= wdata_i;
      status_q <= status_base | admit;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_MASK: rdata_o = mask_q;
      SEL_PRIO: rdata_o = prio_q;
      SEL_STAT: rdata_o = status_q;
      default:  rdata_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/irq_power_gate.sv
module irq_power_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  input  logic doze_set_i,
  input  logic sleep_set_i,
  output logic doze_o,
  output logic sleep_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doze_o  <= 1'b0;
      sleep_o <= 1'b0;
    end else if (wake_i) begin
      doze_o  <= 1'b0;
      sleep_o <= 1'b0;
    end else begin
      if (doze_set_i)  doze_o  <= 1'b1;
      if (sleep_set_i) sleep_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic ie_i,
  output logic exc_o
);
  logic armed_q;

  assign exc_o = armed_q & pend_i & ie_i;

  always_ff @(posedge clk) begin
    if (!rst_n)               armed_q <= 1'b1;
    else if (!pend_i || !ie_i) armed_q <= 1'b1;
    else if (exc_o)            armed_q <= 1'b0;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int UNMASKED  = 2,
  localparam int SEL_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 ie_i,
  input  logic [SEL_W-1:0]     reg_sel_i,
  input  logic                 reg_we_i,
  input  logic [NUM_LINES-1:0] reg_wdata_i,
  output logic [NUM_LINES-1:0] reg_rdata_o,
  input  logic                 doze_set_i,
  input  logic                 sleep_set_i,
  output logic                 doze_en_o,
  output logic                 sleep_en_o,
  output logic                 exc_o
);
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] mask_q;

  irq_status_bank #(.NUM_LINES(NUM_LINES), .UNMASKED(UNMASKED)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .sel_i    (reg_sel_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .status_o (status_q),
    .mask_o   (mask_q)
  );

  irq_power_gate u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_i      (|req_i),
    .doze_set_i  (doze_set_i),
    .sleep_set_i (sleep_set_i),
    .doze_o      (doze_en_o),
    .sleep_o     (sleep_en_o)
  );

  irq_deliver u_dlv (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (|status_q),
    .ie_i   (ie_i),
    .exc_o  (exc_o)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] req_i,
  input logic                 ie_i,
  input logic                 reg_we_i,
  input logic [NUM_LINES-1:0] status_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic                 doze_en_o,
  input logic                 sleep_en_o,
  input logic                 exc_o
);
  // R3
  low_line_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[0] || req_i[1]) |=> (status_q[0] || status_q[1]));

  // R4
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we_i && (req_i & (mask_q | 'h3)) == '0) |=> $stable(status_q));

  // R5
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> (!doze_en_o && !sleep_en_o));

  // R6
  exc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (ie_i && status_q != '0));

  // R8
  exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |=> !exc_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .ie_i       (ie_i),
  .reg_we_i   (reg_we_i),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .doze_en_o  (doze_en_o),
  .sleep_en_o (sleep_en_o),
  .exc_o      (exc_o)
);

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] req;
  logic        ie;
  logic [1:0]  sel;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        doze_set, sleep_set, doze_en, sleep_en, exc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_mask, m_prio, m_stat;
  logic        m_doze, m_sleep, m_armed;

  always #4 clk = ~clk;

  irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ie_i(ie),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .doze_set_i(doze_set), .sleep_set_i(sleep_set),
    .doze_en_o(doze_en), .sleep_en_o(sleep_en), .exc_o(exc)
  );

  function automatic logic [31:0] m_read();
    case (sel)
      2'd0: return m_mask;
      2'd1: return m_prio;
      2'd2: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic m_exc();
    return m_armed && (m_stat != 0) && ie;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic m_update();
    logic [31:0] nstat;
    logic        e;
    e = m_exc();
    if (!rst_n) begin
      m_mask = 0; m_prio = 0; m_stat = 0;
      m_doze = 0; m_sleep = 0; m_armed = 1;
      return;
    end
    nstat = (we && sel == 2'd2) ? wdata : m_stat;
    for (int i = 0; i < 32; i++)
      if (req[i] && (i < 2 || m_mask[i])) nstat[i] = 1'b1;
    if (m_stat == 0 || !ie) m_armed = 1;
    else if (e) m_armed = 0;
    if (we && sel == 2'd0) m_mask = wdata;
    if (we && sel == 2'd1) m_prio = wdata;
    m_stat = nstat;
    if (req != 0) begin
      m_doze = 0; m_sleep = 0;
    end else begin
      if (doze_set)  m_doze  = 1;
      if (sleep_set) m_sleep = 1;
    end
  endtask

  // inputs already driven after a negedge; compare, then advance one clock
  task automatic step(string tag);
    #1;
    chk(tag, "rdata", rdata, m_read());
    chk(tag, "exc", {31'b0, exc}, {31'b0, m_exc()});
    chk(tag, "doze", {31'b0, doze_en}, {31'b0, m_doze});
    chk(tag, "sleep", {31'b0, sleep_en}, {31'b0, m_sleep});
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic idle();
    req = 0; we = 0; doze_set = 0; sleep_set = 0; wdata = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d, string tag);
    sel = s; we = 1; wdata = d; step(tag);
    we = 0;
  endtask

  initial begin
    rst_n = 0; idle(); ie = 0; sel = 2'd2;
    m_mask = 'x; m_prio = 'x; m_stat = 'x; m_doze = 'x; m_sleep = 'x; m_armed = 1;
    @(negedge clk);
    @(posedge clk); m_update(); @(negedge clk);
    @(posedge clk); m_update(); @(negedge clk);
    rst_n = 1;
    // R1 reset values
    sel = 2'd0; step("R1");
    sel = 2'd1; step("R1");
    sel = 2'd2; step("R1");
    // R11 mask write and combinational read
    wr(2'd0, 32'h0000_0010, "R11");
    sel = 2'd0; step("R11");
    // R2 enabled line latches
    sel = 2'd2; req = 32'h10; step("R2");
    req = 0; step("R2");
    // R4 masked line ignored
    wr(2'd2, 32'h0, "R9");
    req = 32'h20; step("R4");
    req = 0; sel = 2'd2; step("R4");
    // R3 unmaskable lines with zero mask
    wr(2'd0, 32'h0, "R3");
    sel = 2'd2; req = 32'h2; step("R3");
    req = 32'h1; step("R3");
    req = 0; step("R3");
    // R7 pending while ie low
    for (int k = 0; k < 5; k++) step("R7");
    ie = 1; step("R7");
    // R8 no repeat while pending stays
    for (int k = 0; k < 4; k++) step("R8");
    ie = 0; step("R8");
    ie = 1; step("R8");
    step("R8");
    // R9 write zero with same-edge request
    sel = 2'd2; we = 1; wdata = 0; req = 32'h1; step("R9");
    we = 0; req = 0; step("R9");
    wr(2'd2, 32'h0, "R9");
    step("R8");
    req = 32'h2; step("R6");
    req = 0; step("R6");
    step("R6");
    wr(2'd2, 32'h0, "R6");
    // R10 priority storage without effect
    wr(2'd1, 32'hFFFF_FFFF, "R10");
    sel = 2'd1; step("R10");
    sel = 2'd2; req = 32'h100; step("R10");
    req = 0; step("R10");
    wr(2'd1, 32'hA5A5_0F0F, "R10");
    sel = 2'd1; step("R10");
    // R2 select code 3 reads zero and ignores writes
    wr(2'd3, 32'h1234_5678, "R2");
    sel = 2'd3; step("R2");
    sel = 2'd0; step("R2");
    sel = 2'd1; step("R2");
    // R5 wake behaviour
    doze_set = 1; sleep_set = 1; step("R5");
    doze_set = 0; sleep_set = 0; step("R5");
    req = 32'h8000_0000; step("R5");
    req = 0; step("R5");
    doze_set = 1; step("R5");
    doze_set = 0; sleep_set = 1; req = 32'h4; step("R5");
    idle(); step("R5");
    // mixed phase against the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      req       = (r[3:0] == 0) ? (32'h1 << r[8:4]) : 32'h0;
      ie        = r[10] | r[11];
      sel       = r[13:12];
      we        = (r[16:14] == 0);
      wdata     = (r[17]) ? 32'h0 : $urandom;
      doze_set  = r[18];
      sleep_set = r[19];
      step("R6");
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule